// File: doc/BRIEF.md
# Programmable Watchdog Timer with Power-Down Gating

This block supervises the firmware of a small 8-bit controller. Once it is armed by a restart strobe, it counts machine cycles and, if software fails to strobe restart again in time, drives a fixed-length reset pulse toward the rest of the chip. The time-out is a power of two minus one machine cycles. The exponent is the base exponent plus a 3-bit select value held in a write-only control byte. The select value only takes hold at the next restart, so a change of time-out never shortens a count already running.

The block follows the controller's power states. In idle the count carries on, so firmware must wake periodically and strobe restart. In power-down the count freezes. When power-down ends by an external interrupt, the low level on the interrupt line keeps the count frozen until the line is released. All control pins are plain levels or single-cycle strobes. The block has no streaming interface, so no back-pressure rules apply.

Top module: `wdt_top`

## Requirements
- R1: While `rst_n` is low and after it is released, `wdt_rst_o` is low, the held select value is 0 and the block is disarmed.
- R2: Before the first `restart` after reset, `wdt_rst_o` never rises, however long the wait.
- R3: With active select S, `wdt_rst_o` rises (2^(BASE_EXP+S) − 1) × PRESCALE + 1 clock cycles after the clock edge that samples `restart`, provided no other restart or freeze intervenes. For example, S=0 gives 2^BASE_EXP − 1 machine cycles and S=7 gives 2^(BASE_EXP+7) − 1.
- R4: Each pulse stays high for exactly PULSE_LEN cycles. The cycle counter and the prescaler then clear, and counting resumes without a new strobe. The next pulse therefore rises PULSE_LEN + (2^(BASE_EXP+S) − 1) × PRESCALE + 1 cycles after the previous rise. Only `rst_n` disarms the block.
- R5: A `restart` clears the prescaler and the counter, so the next pulse is timed from that strobe.
- R6: A write (`sel_wr`) updates the held select value only. The active select is loaded from the held value at a restart. If a write and a restart fall in the same cycle, the restart takes the value held before the write.
- R7: The select value is bits 2..0 of `sel_wdata`. Bits 7..3 are discarded, and writing them has no effect on the time-out.
- R8: `idle_mode` does not change the count or the pulse timing.
- R9: Each cycle sampled with `pwrdn_mode` high delays the pulse by one cycle. No pulse starts in a cycle where `pwrdn_mode` is sampled high.
- R10: After `pwrdn_mode` falls, the count stays frozen for every cycle in which `ext_int_n` is sampled low, and resumes on the first cycle it is sampled high. A low `ext_int_n` with no preceding power-down has no effect.
- R11: A `restart` sampled in the same cycle that a pulse would start cancels that pulse and restarts the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| sel_wr | input | 1 | Strobe writing the control byte |
| sel_wdata | input | 8 | Control byte; bits 2..0 are the time-out select |
| restart | input | 1 | Service strobe; arms the block and clears the count |
| idle_mode | input | 1 | High while the core is idle |
| pwrdn_mode | input | 1 | High while the chip is in power-down |
| ext_int_n | input | 1 | Level of the external wake-up interrupt, active low |
| wdt_rst_o | output | 1 | Reset pulse to the chip |

## Verification
Two pairs of functions can meet in one cycle. The first is a service restart arriving on the very edge at which the terminal count would launch the pulse. The bench times the strobe to the predicted rise edge, and it passes only if no pulse appears and the next one is a full period later. The second is a select write arriving together with a restart. The bench issues both on one edge and judges the result by the pulse timing, which must follow the old select until a later restart.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_DOWN = 2'd2
  } pwr_mode_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRESCALE = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic tick
);
  generate
    if (PRESCALE <= 1) begin : g_bypass
      logic unused_pins;
      assign unused_pins = clk ^ rst_n ^ clr;
      assign tick = en;
    end else begin : g_div
      localparam int PW = $clog2(PRESCALE);
      logic [PW-1:0] phase_q;
      logic          wrap;
      assign wrap = (phase_q == PW'(PRESCALE - 1));
      assign tick = en & wrap;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       phase_q <= '0;
        else if (clr)     phase_q <= '0;
        else if (en)      phase_q <= wrap ? '0 : phase_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/wdt_cycle_counter.sv
module wdt_cycle_counter #(
  parameter int BASE_EXP = 14,
  parameter int SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [SEL_W-1:0] act_sel,
  output logic             at_term
);
  localparam int CW = BASE_EXP + (1 << SEL_W) - 1;

  logic [CW-1:0] count_q;
  logic [CW-1:0] term;

  // all-ones mask of BASE_EXP+sel bits; a full-width shift yields all ones
  assign term    = ~({CW{1'b1}} << (BASE_EXP + int'(act_sel)));
  assign at_term = (count_q == term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count_q <= '0;
    else if (clr)   count_q <= '0;
    else if (tick)  count_q <= count_q + 1'b1;
  end
endmodule

// File: rtl/wdt_power_gate.sv
module wdt_power_gate
  import wdt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic idle_mode,
  input  logic pwrdn_mode,
  input  logic ext_int_n,
  output logic frozen
);
  pwr_mode_e mode;
  logic      wake_hold_q;

  always_comb begin
    if (pwrdn_mode)     mode = PM_DOWN;
    else if (idle_mode) mode = PM_IDLE;
    else                mode = PM_RUN;
  end

  // idle keeps the oscillator running: only power-down and its wake hold freeze
  assign frozen = (mode == PM_DOWN) | (wake_hold_q & ~ext_int_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 wake_hold_q <= 1'b0;
    else if (mode == PM_DOWN)   wake_hold_q <= 1'b1;
    else if (ext_int_n)         wake_hold_q <= 1'b0;
  end
endmodule

// File: rtl/wdt_top.sv
module wdt_top #(
  parameter int BASE_EXP  = 14,
  parameter int SEL_W     = 3,
  parameter int REG_W     = 8,
  parameter int PRESCALE  = 12,
  parameter int PULSE_LEN = 96
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_wr,
  input  logic [REG_W-1:0] sel_wdata,
  input  logic             restart,
  input  logic             idle_mode,
  input  logic             pwrdn_mode,
  input  logic             ext_int_n,
  output logic             wdt_rst_o
);
  localparam int PCW = $clog2(PULSE_LEN + 1);

  logic [SEL_W-1:0] sel_hold_q;
  logic [SEL_W-1:0] sel_act_q;
  logic             armed_q;
  logic [PCW-1:0]   pulse_q;

  logic frozen, tick, at_term;
  logic pulse_on, pulse_last, expire, count_en, clr_count;
  logic rsv_unused;

  assign rsv_unused = ^sel_wdata[REG_W-1:SEL_W];

  assign pulse_on   = (pulse_q != '0);
  assign pulse_last = (pulse_q == PCW'(1));
  assign expire     = armed_q & at_term & ~frozen & ~pulse_on & ~restart;
  assign count_en   = armed_q & ~frozen & ~pulse_on & ~at_term;
  assign clr_count  = restart | pulse_last;
  assign wdt_rst_o  = pulse_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_hold_q <= '0;
      sel_act_q  <= '0;
      armed_q    <= 1'b0;
    end else begin
      if (sel_wr)  sel_hold_q <= sel_wdata[SEL_W-1:0];
      if (restart) begin
        sel_act_q <= sel_hold_q;
        armed_q   <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pulse_q <= '0;
    else if (expire)   pulse_q <= PCW'(PULSE_LEN);
    else if (pulse_on) pulse_q <= pulse_q - 1'b1;
  end

  wdt_power_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .idle_mode  (idle_mode),
    .pwrdn_mode (pwrdn_mode),
    .ext_int_n  (ext_int_n),
    .frozen     (frozen)
  );

  wdt_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr_count),
    .en    (count_en),
    .tick  (tick)
  );

  wdt_cycle_counter #(.BASE_EXP(BASE_EXP), .SEL_W(SEL_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr_count),
    .tick    (tick),
    .act_sel (sel_act_q),
    .at_term (at_term)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int PULSE_LEN = 96
) (
  input logic clk,
  input logic rst_n,
  input logic restart,
  input logic pwrdn_mode,
  input logic wdt_rst_o
);
  int   hi_len_q;
  logic seen_restart_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_len_q       <= 0;
      seen_restart_q <= 1'b0;
    end else begin
      hi_len_q <= wdt_rst_o ? hi_len_q + 1 : 0;
      if (restart) seen_restart_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) assert_reset_quiet_R1: assert (!wdt_rst_o);
  end

  assert_silent_until_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_restart_q |-> !wdt_rst_o);

  assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdt_rst_o && hi_len_q != 0) |-> hi_len_q == PULSE_LEN);

  assert_no_rise_in_pwrdn_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwrdn_mode && !wdt_rst_o) |=> !wdt_rst_o);

  assert_restart_cancels_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !wdt_rst_o) |=> !wdt_rst_o);
endmodule

bind wdt_top wdt_checker #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .restart    (restart),
  .pwrdn_mode (pwrdn_mode),
  .wdt_rst_o  (wdt_rst_o)
);

// File: tb/sim_wdt_top.sv
`timescale 1ns/1ps
module sim_wdt_top;
  localparam int BE = 3;
  localparam int PS = 3;
  localparam int PL = 5;

  typedef struct {
    int    at;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_wr = 1'b0;
  logic [7:0] sel_wdata = 8'h00;
  logic       restart = 1'b0;
  logic       idle_mode = 1'b0;
  logic       pwrdn_mode = 1'b0;
  logic       ext_int_n = 1'b1;
  logic       wdt_rst_o;

  int   cyc = 0;
  int   n_tests = 0;
  int   n_fail = 0;
  int   n_pulse = 0;
  int   hi_cnt = 0;
  logic prev_o = 1'b0;
  bit   done = 1'b0;
  exp_t exp_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdt_top #(.BASE_EXP(BE), .SEL_W(3), .REG_W(8), .PRESCALE(PS), .PULSE_LEN(PL)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
    .restart(restart), .idle_mode(idle_mode), .pwrdn_mode(pwrdn_mode),
    .ext_int_n(ext_int_n), .wdt_rst_o(wdt_rst_o)
  );

  task automatic check(bit ok, string tag, int act, int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic int period(int s);
    return ((1 << (BE + s)) - 1) * PS;
  endfunction

  task automatic push(int at, string tag);
    exp_t e;
    e.at  = at;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: pops one expected rise per observed rise, checks pulse width
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_o = 1'b0;
      hi_cnt = 0;
    end else begin
      if (wdt_rst_o && !prev_o) begin
        n_pulse++;
        if (exp_q.size() == 0) check(1'b0, "R2/unexpected pulse", cyc, -1);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          check(cyc == e.at, e.tag, cyc, e.at);
        end
      end
      if (wdt_rst_o) hi_cnt++;
      else if (prev_o) begin
        check(hi_cnt == PL, "R4 width", hi_cnt, PL);
        hi_cnt = 0;
      end
      prev_o = wdt_rst_o;
    end
  end

  task automatic wait_until(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic kick(output int edge_no);
    restart = 1'b1;
    edge_no = cyc + 1;
    @(negedge clk);
    restart = 1'b0;
  endtask

  task automatic write_sel(logic [7:0] d);
    sel_wr    = 1'b1;
    sel_wdata = d;
    @(negedge clk);
    sel_wr = 1'b0;
  endtask

  task automatic power_down(int d, int h);
    pwrdn_mode = 1'b1;
    ext_int_n  = 1'b0;
    repeat (d) @(negedge clk);
    pwrdn_mode = 1'b0;
    repeat (h) @(negedge clk);
    ext_int_n = 1'b1;
  endtask

  task automatic do_reset(string tag);
    check(exp_q.size() == 0, {tag, " missing pulse"}, exp_q.size(), 0);
    exp_q.delete();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(wdt_rst_o == 1'b0, "R1 output in reset", wdt_rst_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int e, e2, r;
    @(negedge clk);
    do_reset("R1");

    // R1/R2: disarmed after reset, no pulse however long
    repeat (120) @(negedge clk);
    check(n_pulse == 0, "R2 pulses before restart", n_pulse, 0);
    check(wdt_rst_o == 1'b0, "R1 output after reset", wdt_rst_o, 0);

    // R3/R4: select 0 from reset, automatic repeat
    kick(e);
    r = e + period(0) + 1;
    push(r, "R3 select0 rise");
    push(r + PL + period(0) + 1, "R4 repeat rise");
    wait_until(r + PL + period(0) + 1 + PL + 2);
    do_reset("R4");

    // R7/R8: reserved bits set, idle held high
    idle_mode = 1'b1;
    write_sel(8'hFB);
    kick(e);
    r = e + period(3) + 1;
    push(r, "R7 R8 select3 rise");
    wait_until(r + PL + 2);
    idle_mode = 1'b0;
    do_reset("R7");

    // R6: write and restart in the same cycle use the old select
    sel_wr = 1'b1; sel_wdata = 8'h03;
    kick(e);
    sel_wr = 1'b0;
    r = e + period(0) + 1;
    push(r, "R6 same-cycle old select");
    wait_until(r + PL + 1);
    kick(e2);
    r = e2 + period(3) + 1;
    push(r, "R6 new select at restart");
    wait_until(e2 + 10);
    write_sel(8'h00);
    wait_until(r + PL + 2);
    do_reset("R6");

    // R5: second restart postpones the pulse
    kick(e);
    wait_until(e + 14);
    kick(e2);
    push(e2 + period(0) + 1, "R5 restart postpones");
    wait_until(e2 + period(0) + 1 + PL + 2);
    do_reset("R5");

    // R9: power-down early in the count
    kick(e);
    push(e + period(0) + 1 + 10, "R9 freeze mid count");
    wait_until(e + 4);
    power_down(10, 0);
    wait_until(e + period(0) + 11 + PL + 2);
    do_reset("R9");

    // R9: power-down spanning the terminal count
    kick(e);
    push(e + period(0) + 1 + 30, "R9 freeze over terminal");
    wait_until(e + 19);
    power_down(30, 0);
    wait_until(e + period(0) + 31 + PL + 2);
    do_reset("R9b");

    // R10: interrupt held low after power-down extends the freeze
    kick(e);
    push(e + period(0) + 1 + 17, "R10 wake hold");
    wait_until(e + 3);
    power_down(10, 7);
    wait_until(e + period(0) + 18 + PL + 2);
    do_reset("R10");

    // R10: interrupt low without power-down has no effect
    kick(e);
    push(e + period(0) + 1, "R10 no hold without power-down");
    wait_until(e + 3);
    ext_int_n = 1'b0;
    repeat (10) @(negedge clk);
    ext_int_n = 1'b1;
    wait_until(e + period(0) + 1 + PL + 2);
    do_reset("R10b");

    // R11: restart on the edge the pulse would start
    kick(e);
    wait_until(e + period(0));
    kick(e2);
    check(e2 == e + period(0) + 1, "R11 strobe placement", e2, e + period(0) + 1);
    push(e2 + period(0) + 1, "R11 cancelled then rescheduled");
    wait_until(e2 + 2);
    check(n_pulse == 0 || wdt_rst_o == 1'b0, "R11 no pulse at cancel", wdt_rst_o, 0);
    wait_until(e2 + period(0) + 1 + PL + 2);
    do_reset("R11");

    // R3: largest select
    write_sel(8'h07);
    kick(e);
    r = e + period(7) + 1;
    push(r, "R3 select7 rise");
    wait_until(r + PL + 2);
    do_reset("R3");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule